// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block produces a pulse-width-modulated output from an 8-bit period timer. The timer advances once every four input clocks times a selectable prescale factor of 1, 4 or 16. A 2-bit sub-count inside each timer step stretches the timer into a 10-bit time base, so the high time can be set to one prescaled clock.

Software loads a 10-bit duty value in two parts: eight upper bits and two lower bits, each with its own write strobe. Either part may be written at any moment. The written value only becomes the active duty when the running period ends. The active duty can be read back on its own output. A postscaler counts period ends and emits a pulse on every Nth one. This pulse can pace a slower update loop and leaves the PWM frequency untouched.

Top module: `pwm_dbuf10`

## Requirements
- R1: After a synchronous reset, `pwm_out`, `post_evt` and `duty_active` are 0 and the stored duty parts are 0.
- R2: With `pwm_en` high, one PWM period lasts (period_val + 1) × 4 × P clocks, where P is 1 for `presc_sel` = 00, 4 for 01 and 16 for 10 or 11.
- R3: At each period end with a non-zero active duty D = {upper bits, lower 2 bits}, the output goes high and stays high for D × P clocks.
- R4: A duty write takes effect only at the next period end. `duty_active` changes at nothing but a period end. A write made in the clock that ends a period is applied one period later.
- R5: A duty of 0 keeps the output low for the entire period.
- R6: A duty with D × P not less than the period length keeps the output high through the whole period.
- R7: While `pwm_en` is low, the output is forced low and the timer is held at zero. After enable, the first period starts with the output low.
- R8: `post_evt` pulses for one clock on every (post_sel + 1)th period end, and does not change the period.
- R9: A write of only the upper part or only the lower part leaves the other part unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwm_en | input | 1 | Run enable; low clears the output latch and the timer |
| presc_sel | input | 2 | Prescale select: 00 = 1, 01 = 4, 1x = 16 |
| period_val | input | 8 | Period limit for the timer |
| duty_hi | input | 8 | Upper eight duty bits |
| duty_hi_wr | input | 1 | Write strobe for the upper duty bits |
| duty_lo | input | 2 | Lower two duty bits |
| duty_lo_wr | input | 1 | Write strobe for the lower duty bits |
| post_sel | input | 4 | Postscale divide minus one |
| pwm_out | output | 1 | PWM output |
| duty_active | output | 10 | Active (buffered) duty value |
| post_evt | output | 1 | One-clock postscaled period-end pulse |

## Verification
A duty write can land in the same clock that ends a period. In that clock the block must hand the old stored value to the active register and keep the new value for the period after. The bench provokes this by pulsing a write strobe in the last clock of a period. A behavioural model compares `duty_active` and `pwm_out` on every clock, and the high time is measured over the next two periods. Setting the output at a period end and clearing it on a duty match also meet in one clock when the duty is zero. This case is judged by the output staying low across whole periods.

// File: rtl/pwm_pkg.sv
// Shared helpers for the PWM generator.
// Assumes a 2-bit prescale select with encodings 00, 01 and 1x.
package pwm_pkg;

    // Returns log2 of the prescale factor chosen by the select field.
    function automatic logic [2:0] presc_shift(input logic [1:0] sel);
        case (sel)
            2'b00:   return 3'd0;
            2'b01:   return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/pwm_timebase.sv
// Period timer with its prescaler and sub-count.
// The clock counter spans one timer step (4 x prescale clocks). Its upper
// bits above the prescale shift form the 2-bit sub-count. The next-state
// values are exported so the compare can act in the same clock.
// Assumes that presc_sel is changed only while en is low.
module pwm_timebase
    import pwm_pkg::*;
#(
    parameter int TMR_W = 8,
    parameter int SUB_W = 2,
    parameter int CNT_W = SUB_W + 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [1:0]       presc_sel,
    input  logic [TMR_W-1:0] period,
    output logic [TMR_W-1:0] tmr_nxt,
    output logic [SUB_W-1:0] sub_nxt,
    output logic             aligned_nxt,
    output logic             roll
);
    logic [TMR_W-1:0] tmr_q;
    logic [CNT_W-1:0] cnt_q, cnt_nxt, last, pmask;
    logic [2:0]       shift;
    logic             step;

    // Decode the step length and the prescale mask from the select field.
    always_comb begin
        shift = presc_shift(presc_sel);
        last  = CNT_W'((32'd1 << (SUB_W + 32'(shift))) - 32'd1);
        pmask = CNT_W'((32'd1 << shift) - 32'd1);
    end

    // Next-state logic for the clock counter and the timer.
    always_comb begin
        step = (cnt_q >= last);
        roll = en && step && (tmr_q == period);
        if (!en) begin
            cnt_nxt = '0;
            tmr_nxt = '0;
        end else if (step) begin
            cnt_nxt = '0;
            tmr_nxt = (tmr_q == period) ? '0 : tmr_q + 1'b1;
        end else begin
            cnt_nxt = cnt_q + 1'b1;
            tmr_nxt = tmr_q;
        end
        sub_nxt     = SUB_W'(cnt_nxt >> shift);
        aligned_nxt = ((cnt_nxt & pmask) == '0);
    end

    // Timer and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            tmr_q <= '0;
        end else begin
            cnt_q <= cnt_nxt;
            tmr_q <= tmr_nxt;
        end
    end

    // R2: a period end restarts the time base at zero.
    a_r2_roll_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        roll |=> (tmr_q == '0 && cnt_q == '0));

    // R7: an idle block holds its timer at zero.
    a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (tmr_q == '0));

endmodule

// File: rtl/pwm_duty_buf.sv
// Two-stage duty storage. The first stage takes software writes at any
// time. The second stage (the active duty) loads from the first stage only
// at a period end, so a period never sees a half-updated value.
module pwm_duty_buf #(
    parameter int HI_W = 8,
    parameter int LO_W = 2,
    localparam int D_W = HI_W + LO_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            hi_wr,
    input  logic [HI_W-1:0] hi_d,
    input  logic            lo_wr,
    input  logic [LO_W-1:0] lo_d,
    input  logic            roll,
    output logic [D_W-1:0]  pend,
    output logic [D_W-1:0]  act_q,
    output logic [D_W-1:0]  act_nxt
);
    logic [HI_W-1:0] hi_q;
    logic [LO_W-1:0] lo_q;

    // Software-written stage, each part with its own strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            if (hi_wr) hi_q <= hi_d;
            if (lo_wr) lo_q <= lo_d;
        end
    end

    // Pending value and the value the active stage is about to take.
    always_comb begin
        pend    = {hi_q, lo_q};
        act_nxt = roll ? pend : act_q;
    end

    // Active stage, loaded at period end only.
    always_ff @(posedge clk) begin
        if (!rst_n) act_q <= '0;
        else        act_q <= act_nxt;
    end

    // R4: the active duty only moves at a period end.
    a_r4_active_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !roll |=> $stable(act_q));

endmodule

// File: rtl/pwm_postscale.sv
// Counts period ends and pulses once every (div_sel + 1) of them.
// Cleared while the block is disabled.
module pwm_postscale #(
    parameter int POST_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              roll,
    input  logic [POST_W-1:0] div_sel,
    output logic              evt
);
    logic [POST_W-1:0] cnt_q;

    // Period-end counter and its registered pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            cnt_q <= '0;
            evt   <= 1'b0;
        end else begin
            evt <= 1'b0;
            if (roll) begin
                if (cnt_q == div_sel) begin
                    cnt_q <= '0;
                    evt   <= 1'b1;
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

    // R8: the pulse only follows a period end.
    a_r8_evt_on_roll: assert property (@(posedge clk) disable iff (!rst_n)
        !roll |=> !evt);

endmodule

// File: rtl/pwm_dbuf10.sv
// Top of the double-buffered PWM generator.
// The output latch is set at a period end and cleared when the next
// {timer, sub-count} equals the active duty on a prescale boundary.
// Clearing takes priority, so a zero duty never sets the latch. A duty
// beyond the period never matches, so the latch stays high.
module pwm_dbuf10 #(
    parameter int TMR_W  = 8,
    parameter int SUB_W  = 2,
    parameter int POST_W = 4,
    localparam int D_W   = TMR_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_en,
    input  logic [1:0]        presc_sel,
    input  logic [TMR_W-1:0]  period_val,
    input  logic [TMR_W-1:0]  duty_hi,
    input  logic              duty_hi_wr,
    input  logic [SUB_W-1:0]  duty_lo,
    input  logic              duty_lo_wr,
    input  logic [POST_W-1:0] post_sel,
    output logic              pwm_out,
    output logic [D_W-1:0]    duty_active,
    output logic              post_evt
);
    logic [TMR_W-1:0] tmr_nxt;
    logic [SUB_W-1:0] sub_nxt;
    logic             aligned_nxt, roll, match, out_q;
    logic [D_W-1:0]   pend, act_nxt;

    pwm_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_tb (
        .clk(clk), .rst_n(rst_n), .en(pwm_en), .presc_sel(presc_sel),
        .period(period_val), .tmr_nxt(tmr_nxt), .sub_nxt(sub_nxt),
        .aligned_nxt(aligned_nxt), .roll(roll)
    );

    pwm_duty_buf #(.HI_W(TMR_W), .LO_W(SUB_W)) u_buf (
        .clk(clk), .rst_n(rst_n), .hi_wr(duty_hi_wr), .hi_d(duty_hi),
        .lo_wr(duty_lo_wr), .lo_d(duty_lo), .roll(roll), .pend(pend),
        .act_q(duty_active), .act_nxt(act_nxt)
    );

    pwm_postscale #(.POST_W(POST_W)) u_post (
        .clk(clk), .rst_n(rst_n), .en(pwm_en), .roll(roll),
        .div_sel(post_sel), .evt(post_evt)
    );

    // Duty compare against the time base the next clock will show.
    always_comb begin
        match = pwm_en && aligned_nxt && ({tmr_nxt, sub_nxt} == act_nxt);
    end

    // Output latch: cleared on disable or match, set at a period end.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwm_en) out_q <= 1'b0;
        else if (match)        out_q <= 1'b0;
        else if (roll)         out_q <= 1'b1;
    end

    assign pwm_out = out_q;

    // R5: a zero duty handed over at a period end keeps the output low.
    a_r5_zero_low: assert property (@(posedge clk) disable iff (!rst_n)
        (roll && pend == '0) |=> !pwm_out);

    // R3: a non-zero duty handed over at a period end sets the output.
    a_r3_roll_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (roll && pend != '0) |=> pwm_out);

    // R7: disabling forces the output low.
    a_r7_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        !pwm_en |=> !pwm_out);

endmodule

// File: tb/pwm_dbuf10_bench.sv
module pwm_dbuf10_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_en = 1'b0;
    logic [1:0] presc_sel = 2'b00;
    logic [7:0] period_val = 8'd9;
    logic [7:0] duty_hi = 8'd0;
    logic       duty_hi_wr = 1'b0;
    logic [1:0] duty_lo = 2'd0;
    logic       duty_lo_wr = 1'b0;
    logic [3:0] post_sel = 4'd0;
    logic       pwm_out, post_evt;
    logic [9:0] duty_active;

    int checks = 0, errors = 0;
    bit done = 1'b0;
    string cur_req = "R1";

    // model state
    int m_pos = 0, m_act = 0, m_mhi = 0, m_mlo = 0, m_post = 0;
    bit m_out = 0, m_pevt = 0;

    always #10ns clk = ~clk;

    pwm_dbuf10 u_pwm_dbuf10 (
        .clk(clk), .rst_n(rst_n), .pwm_en(pwm_en), .presc_sel(presc_sel),
        .period_val(period_val), .duty_hi(duty_hi), .duty_hi_wr(duty_hi_wr),
        .duty_lo(duty_lo), .duty_lo_wr(duty_lo_wr), .post_sel(post_sel),
        .pwm_out(pwm_out), .duty_active(duty_active), .post_evt(post_evt)
    );

    function automatic int pfac();
        return (presc_sel == 2'b00) ? 1 : (presc_sel == 2'b01) ? 4 : 16;
    endfunction

    function automatic int plen();
        return (int'(period_val) + 1) * 4 * pfac();
    endfunction

    // Behavioural reference model, advanced on every clock edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pos = 0; m_act = 0; m_mhi = 0; m_mlo = 0; m_post = 0;
            m_out = 0; m_pevt = 0;
        end else begin
            m_pevt = 0;
            if (!pwm_en) begin
                m_pos = 0; m_out = 0; m_post = 0;
            end else if (m_pos >= plen() - 1) begin
                m_act = m_mhi * 4 + m_mlo;
                m_pos = 0;
                m_out = (m_act != 0);
                if (m_post == int'(post_sel)) begin m_pevt = 1; m_post = 0; end
                else m_post++;
            end else begin
                m_pos++;
                if (m_pos == m_act * pfac()) m_out = 0;
            end
            if (duty_hi_wr) m_mhi = int'(duty_hi);
            if (duty_lo_wr) m_mlo = int'(duty_lo);
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_req, "pwm_out", int'(pwm_out), int'(m_out));
            check("R4", "duty_active", int'(duty_active), m_act);
            check("R8", "post_evt", int'(post_evt), int'(m_pevt));
        end
    end

    task automatic write_duty(input int d);
        @(negedge clk);
        duty_hi = 8'(d / 4); duty_lo = 2'(d % 4);
        duty_hi_wr = 1'b1; duty_lo_wr = 1'b1;
        @(negedge clk);
        duty_hi_wr = 1'b0; duty_lo_wr = 1'b0;
    endtask

    task automatic align();
        @(negedge clk);
        while (m_pos != 0) @(negedge clk);
    endtask

    // Count high samples over one period from an aligned start; optional write at index wr_at.
    task automatic measure(input int wr_at, input int nd, output int hi);
        int len;
        len = plen();
        hi = 0;
        for (int i = 0; i < len; i++) begin
            if (pwm_out) hi++;
            if (i == wr_at) begin
                duty_hi = 8'(nd / 4); duty_lo = 2'(nd % 4);
                duty_hi_wr = 1'b1; duty_lo_wr = 1'b1;
            end else begin
                duty_hi_wr = 1'b0; duty_lo_wr = 1'b0;
            end
            @(negedge clk);
        end
        duty_hi_wr = 1'b0; duty_lo_wr = 1'b0;
    endtask

    // Clocks between two rising edges of the output.
    task automatic rise_gap(output int gap);
        bit prev;
        int guard;
        gap = 0; guard = 0;
        prev = pwm_out;
        @(negedge clk);
        while (!(pwm_out && !prev) && guard < 5000) begin
            prev = pwm_out; guard++; @(negedge clk);
        end
        prev = pwm_out;
        @(negedge clk); gap = 1;
        while (!(pwm_out && !prev) && gap < 5000) begin
            prev = pwm_out; gap++; @(negedge clk);
        end
    endtask

    task automatic restart(input logic [1:0] ps, input logic [7:0] per);
        @(negedge clk);
        pwm_en = 1'b0;
        @(negedge clk);
        presc_sel = ps; period_val = per;
        @(negedge clk);
        pwm_en = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(20ns * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int h, g;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1", "pwm_out after reset", int'(pwm_out), 0);
        check("R1", "duty_active after reset", int'(duty_active), 0);
        check("R1", "post_evt after reset", int'(post_evt), 0);

        // R7: first period after enable stays low; P=1, period 9 -> 40 clocks
        cur_req = "R7";
        write_duty(22);
        @(negedge clk); pwm_en = 1'b1;
        h = 0;
        for (int i = 0; i < 39; i++) begin @(negedge clk); if (pwm_out) h++; end
        check("R7", "high clocks in first period", h, 0);

        cur_req = "R3";
        align(); measure(-1, 0, h);
        check("R3", "high clocks duty 22 P=1", h, 22);
        rise_gap(g);
        check("R2", "period P=1", g, 40);

        // P=4, period 3 -> 64 clocks; duty 7 -> 28 clocks
        cur_req = "R2";
        write_duty(7);
        restart(2'b01, 8'd3);
        align(); align(); measure(-1, 0, h);
        check("R3", "high clocks duty 7 P=4", h, 28);
        rise_gap(g);
        check("R2", "period P=4", g, 64);

        // P=16, period 1 -> 128 clocks; duty 3 -> 48 clocks
        write_duty(3);
        restart(2'b10, 8'd1);
        align(); align(); measure(-1, 0, h);
        check("R3", "high clocks duty 3 P=16", h, 48);
        rise_gap(g);
        check("R2", "period P=16", g, 128);

        // R4: mid-cycle write waits for the next period
        cur_req = "R4";
        write_duty(22);
        restart(2'b00, 8'd9);
        align(); align();
        measure(5, 8, h);
        check("R4", "period with mid-cycle write", h, 22);
        measure(-1, 0, h);
        check("R4", "period after mid-cycle write", h, 8);
        // write in the period-ending clock: applied one period later
        measure(39, 30, h);
        check("R4", "period with end-clock write", h, 8);
        measure(-1, 0, h);
        check("R4", "period after end-clock write (still old)", h, 8);
        measure(-1, 0, h);
        check("R4", "second period after end-clock write", h, 30);

        // R5: zero duty
        cur_req = "R5";
        write_duty(0);
        align(); align(); measure(-1, 0, h);
        check("R5", "high clocks duty 0", h, 0);
        measure(-1, 0, h);
        check("R5", "high clocks duty 0 again", h, 0);

        // R6: duty beyond the period
        cur_req = "R6";
        write_duty(45);
        align(); align(); measure(-1, 0, h);
        check("R6", "high clocks duty 45 of 40", h, 40);
        check("R6", "duty_active shows 45", int'(duty_active), 45);

        // R9: partial writes
        cur_req = "R9";
        @(negedge clk); duty_lo = 2'd1; duty_lo_wr = 1'b1;
        @(negedge clk); duty_lo_wr = 1'b0;
        align(); @(negedge clk);
        check("R9", "lower-only write keeps upper bits", int'(duty_active), 45);
        @(negedge clk); duty_hi = 8'd3; duty_hi_wr = 1'b1;
        @(negedge clk); duty_hi_wr = 1'b0;
        align(); @(negedge clk);
        check("R9", "upper-only write keeps lower bits", int'(duty_active), 13);

        // R8: postscaler every third period end, period unchanged
        cur_req = "R8";
        post_sel = 4'd2;
        restart(2'b00, 8'd9);
        h = 0;
        for (int i = 0; i < 40 * 6 + 2; i++) begin @(negedge clk); if (post_evt) h++; end
        check("R8", "pulses over six periods", h, 2);
        rise_gap(g);
        check("R8", "period with postscaler", g, 40);

        // R7: disable forces low
        cur_req = "R7";
        align(); @(negedge clk);
        pwm_en = 1'b0;
        @(negedge clk);
        check("R7", "output low after disable", int'(pwm_out), 0);
        repeat (5) @(negedge clk);
        check("R7", "output stays low while disabled", int'(pwm_out), 0);

        finish_run();
    end
endmodule